// File: doc/BRIEF.md
# Zero-Sequence Offset Selector for Capacitor Balancing

A four-level phase leg draws its output from a DC link that is split into three series capacitors. A common-mode offset is added to all three phase references. The modulated voltage between the lines does not change, but the currents drawn from the two internal tap points of the link do change. This block takes one sample per switching period and picks that offset. The sample holds three fundamental references in per-unit form, where 1.0 is one capacitor's share of the link. It also holds the three phase currents, the three capacitor voltages and the total link voltage.

From the smallest and largest fundamental, the block finds the band of offsets that keeps every reference inside 0 to 3. It spreads a fixed number of candidate offsets evenly across that band and scores one candidate per clock cycle. For each candidate it estimates the two tap-point currents from the level (integer part) and the duty (fractional part) of each shifted reference. It converts those into capacitor currents. It then scores how fast the stored energy moves away from an equal split. The candidate with the smallest score wins, and the shifted references are returned. When the fundamentals span more than three units, no offset fits. In that case the midpoint of the reversed band is used and each reference is clamped.

Input and output use valid/ready. A sample is taken only when `in_ready` is high, which happens only while the block is idle with no result pending. A result stays on the outputs, with `out_valid` high and the data stable, until the consumer raises `out_ready`. While a result is held, the block accepts no new sample. That back-pressure reaches the producer through `in_ready`.

Top module: `zsb_selector`

## Requirements
- R1: With the fundamentals' minimum m and maximum M, the band is lo = −m to hi = 3.0 − M. When hi ≥ lo, candidate k (0 ≤ k < NCAND) is lo + floor((hi − lo)·k / (NCAND − 1)) in raw fraction units, and candidates are scored in increasing k.
- R2: Fundamentals are signed with FRAC fractional bits (default Q3.12, 16 bits). Each output reference is unsigned with 2 integer bits and FRAC fractional bits, and equals its fundamental plus the chosen offset.
- R3: For a shifted reference u, the level is floor(u) and the duty is frac(u). The lower-tap current sums current·frac at level 0 and current·(1 − frac) at level 1. The upper-tap current sums current·frac at level 1 and current·(1 − frac) at level 2. Level 3 contributes to neither.
- R4: The capacitor currents, bottom to top, are −iN2/3 − 2iN1/3, iN1/3 − iN2/3 and 2iN2/3 + iN1/3. The score is the sum of (vcap − vlink/3)·icap over the three capacitors, and the lowest score is selected.
- R5: When scores are equal, the earlier candidate (the lower offset) is kept.
- R6: When hi < lo, the offset is floor((lo + hi)/2), and each output reference is clamped to the range 0 to 3.0.
- R7: `out_valid` rises NCAND clock edges after the accepting edge for a normal band, and one edge after it for a reversed band. `done` is high for exactly the first cycle of each result.
- R8: `in_ready` is high only when idle with no held result. A held result keeps `out_valid` high and its references unchanged until a cycle with `out_ready` high completes the transfer.
- R9: After reset, `in_ready` is 1, `out_valid` and `done` are 0, and all references are 0.
- R10: `in_valid` asserted while a sample is being searched has no effect on the result under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| fund_a | input | FRAC+4 | Phase A fundamental, signed per-unit |
| fund_b | input | FRAC+4 | Phase B fundamental, signed per-unit |
| fund_c | input | FRAC+4 | Phase C fundamental, signed per-unit |
| cur_a | input | IW | Phase A current, signed |
| cur_b | input | IW | Phase B current, signed |
| cur_c | input | IW | Phase C current, signed |
| vcap_bot | input | IW | Bottom capacitor voltage, signed |
| vcap_mid | input | IW | Middle capacitor voltage, signed |
| vcap_top | input | IW | Top capacitor voltage, signed |
| vlink | input | IW | Total link voltage, signed |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| ref_a | output | FRAC+2 | Phase A final reference, unsigned per-unit |
| ref_b | output | FRAC+2 | Phase B final reference, unsigned per-unit |
| ref_c | output | FRAC+2 | Phase C final reference, unsigned per-unit |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
Results are due a fixed number of rising edges after the edge that accepts a sample: NCAND edges when the band is normal and one edge when it is reversed. The bench counts edges from acceptance and compares that count with the figure predicted by its own model. It drives stimulus and samples outputs on falling edges only, so each value is read in the cycle after the register that produces it has updated. While a result is held back, the bench checks on every falling edge that the references stay stable and that `done` does not pulse again. After each transfer, it checks that the block is back in the idle state.

// File: rtl/zsb_pkg.sv
package zsb_pkg;
  localparam int NPH = 3;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_SCAN = 2'd1,
    SEL_HOLD = 2'd2
  } sel_state_e;
endpackage

// File: rtl/zsb_range.sv
// Offset band derived from the smallest and largest fundamental.
module zsb_range
  import zsb_pkg::*;
#(
  parameter int FW   = 16,
  parameter int FRAC = 12,
  parameter int CW   = FW + 2
) (
  input  logic signed [FW-1:0] fund [NPH],
  output logic signed [CW-1:0] lo,
  output logic signed [CW-1:0] hi,
  output logic signed [CW-1:0] mid,
  output logic                 empty
);
  localparam logic signed [CW-1:0] THREE = CW'(3 * (2 ** FRAC));

  logic signed [CW-1:0] mn, mx, tot;

  always_comb begin
    mn = CW'(fund[0]);
    mx = CW'(fund[0]);
    for (int p = 1; p < NPH; p++) begin
      if (CW'(fund[p]) < mn) mn = CW'(fund[p]);
      if (CW'(fund[p]) > mx) mx = CW'(fund[p]);
    end
    lo    = -mn;
    hi    = THREE - mx;
    empty = (hi < lo);
    tot   = lo + hi;
    mid   = tot >>> 1;
  end
endmodule

// File: rtl/zsb_phase_wt.sv
// Tap-point weights of one phase from the level and duty of its reference.
module zsb_phase_wt #(
  parameter int FRAC = 12
) (
  input  logic [FRAC+1:0] u,
  output logic [FRAC:0]   w_n1,
  output logic [FRAC:0]   w_n2
);
  localparam logic [FRAC:0] ONE = {1'b1, {FRAC{1'b0}}};

  logic [1:0]    lvl;
  logic [FRAC:0] duty, rest;

  assign lvl  = u[FRAC+1:FRAC];
  assign duty = {1'b0, u[FRAC-1:0]};
  assign rest = ONE - duty;

  always_comb begin
    unique case (lvl)
      2'd0:    begin w_n1 = duty; w_n2 = '0;   end
      2'd1:    begin w_n1 = rest; w_n2 = duty; end
      2'd2:    begin w_n1 = '0;   w_n2 = rest; end
      default: begin w_n1 = '0;   w_n2 = '0;   end
    endcase
  end
endmodule

// File: rtl/zsb_cost.sv
// Score of one candidate offset; the score is nine times the energy-change rate.
module zsb_cost
  import zsb_pkg::*;
#(
  parameter int FW   = 16,
  parameter int FRAC = 12,
  parameter int IW   = 16,
  parameter int CW   = FW + 2
) (
  input  logic signed [FW-1:0] fund  [NPH],
  input  logic signed [CW-1:0] cand,
  input  logic signed [IW-1:0] cur   [NPH],
  input  logic signed [IW-1:0] vcap  [NPH],
  input  logic signed [IW-1:0] vlink,
  output logic signed [CW-1:0] u     [NPH],
  output logic signed [63:0]   cost
);
  logic [FRAC:0]        w1 [NPH];
  logic [FRAC:0]        w2 [NPH];
  logic signed [63:0]   t1 [NPH];
  logic signed [63:0]   t2 [NPH];

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    assign u[g] = CW'(fund[g]) + cand;
    zsb_phase_wt #(.FRAC(FRAC)) u_wt (
      .u    (u[g][FRAC+1:0]),
      .w_n1 (w1[g]),
      .w_n2 (w2[g])
    );
    assign t1[g] = 64'(cur[g]) * $signed(64'(w1[g]));
    assign t2[g] = 64'(cur[g]) * $signed(64'(w2[g]));
  end

  logic signed [63:0] n1, n2;
  logic signed [63:0] ic [NPH];
  logic signed [63:0] dv [NPH];

  always_comb begin
    n1 = '0;
    n2 = '0;
    for (int p = 0; p < NPH; p++) begin
      n1 = n1 + t1[p];
      n2 = n2 + t2[p];
    end
    ic[0] = -n2 - (n1 <<< 1);
    ic[1] = n1 - n2;
    ic[2] = (n2 <<< 1) + n1;
    cost  = '0;
    for (int j = 0; j < NPH; j++) begin
      dv[j] = 64'(vcap[j]) * 64'sd3 - 64'(vlink);
      cost  = cost + dv[j] * ic[j];
    end
  end
endmodule

// File: rtl/zsb_selector.sv
module zsb_selector
  import zsb_pkg::*;
#(
  parameter int FRAC  = 12,
  parameter int IW    = 16,
  parameter int NCAND = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [FRAC+3:0] fund_a,
  input  logic signed [FRAC+3:0] fund_b,
  input  logic signed [FRAC+3:0] fund_c,
  input  logic signed [IW-1:0] cur_a,
  input  logic signed [IW-1:0] cur_b,
  input  logic signed [IW-1:0] cur_c,
  input  logic signed [IW-1:0] vcap_bot,
  input  logic signed [IW-1:0] vcap_mid,
  input  logic signed [IW-1:0] vcap_top,
  input  logic signed [IW-1:0] vlink,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [FRAC+1:0]      ref_a,
  output logic [FRAC+1:0]      ref_b,
  output logic [FRAC+1:0]      ref_c,
  output logic                 done
);
  localparam int FW  = FRAC + 4;
  localparam int OW  = FRAC + 2;
  localparam int CW  = FW + 2;
  localparam int KW  = (NCAND > 2) ? $clog2(NCAND) : 1;
  localparam int NM1 = NCAND - 1;
  localparam logic signed [CW-1:0] THREE = CW'(3 * (2 ** FRAC));

  function automatic logic [OW-1:0] clamp_pu(input logic signed [CW-1:0] v);
    if (v < 0)          return '0;
    else if (v > THREE) return THREE[OW-1:0];
    else                return v[OW-1:0];
  endfunction

  sel_state_e           state;
  logic [KW-1:0]        k_q;
  logic signed [FW-1:0] fund_q [NPH];
  logic signed [IW-1:0] cur_q  [NPH];
  logic signed [IW-1:0] vcap_q [NPH];
  logic signed [IW-1:0] vlink_q;
  logic signed [63:0]   best_cost;
  logic [OW-1:0]        best_ref [NPH];
  logic                 done_q;

  // Range of admissible offsets
  logic signed [CW-1:0] lo, hi, mid;
  logic                 empty;

  zsb_range #(.FW(FW), .FRAC(FRAC), .CW(CW)) u_range (
    .fund  (fund_q),
    .lo    (lo),
    .hi    (hi),
    .mid   (mid),
    .empty (empty)
  );

  // Candidate k sits floor(span*k/(NCAND-1)) above the low edge
  logic signed [31:0]   span, step_off;
  logic signed [CW-1:0] cand;

  always_comb begin
    span     = 32'(hi) - 32'(lo);
    step_off = (span * $signed(32'(k_q))) / NM1;
    cand     = empty ? mid : CW'(32'(lo) + step_off);
  end

  logic signed [CW-1:0] u    [NPH];
  logic signed [63:0]   cost;
  logic [OW-1:0]        uclp [NPH];

  zsb_cost #(.FW(FW), .FRAC(FRAC), .IW(IW), .CW(CW)) u_cost (
    .fund  (fund_q),
    .cand  (cand),
    .cur   (cur_q),
    .vcap  (vcap_q),
    .vlink (vlink_q),
    .u     (u),
    .cost  (cost)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_clp
    assign uclp[g] = clamp_pu(u[g]);
  end

  logic last, better;
  assign last   = (k_q == KW'(NM1));
  assign better = (k_q == '0) || (cost < best_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEL_IDLE;
      k_q       <= '0;
      vlink_q   <= '0;
      best_cost <= '0;
      done_q    <= 1'b0;
      for (int p = 0; p < NPH; p++) begin
        fund_q[p]   <= '0;
        cur_q[p]    <= '0;
        vcap_q[p]   <= '0;
        best_ref[p] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SEL_IDLE: begin
          if (in_valid) begin
            fund_q[0] <= fund_a;   fund_q[1] <= fund_b;   fund_q[2] <= fund_c;
            cur_q[0]  <= cur_a;    cur_q[1]  <= cur_b;    cur_q[2]  <= cur_c;
            vcap_q[0] <= vcap_bot; vcap_q[1] <= vcap_mid; vcap_q[2] <= vcap_top;
            vlink_q   <= vlink;
            k_q       <= '0;
            state     <= SEL_SCAN;
          end
        end
        SEL_SCAN: begin
          if (empty) begin
            for (int p = 0; p < NPH; p++) best_ref[p] <= uclp[p];
            done_q <= 1'b1;
            state  <= SEL_HOLD;
          end else begin
            if (better) begin
              best_cost <= cost;
              for (int p = 0; p < NPH; p++) best_ref[p] <= uclp[p];
            end
            if (last) begin
              done_q <= 1'b1;
              state  <= SEL_HOLD;
            end else begin
              k_q <= k_q + 1'b1;
            end
          end
        end
        SEL_HOLD: begin
          if (out_ready) state <= SEL_IDLE;
        end
        default: state <= SEL_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == SEL_IDLE);
  assign out_valid = (state == SEL_HOLD);
  assign done      = done_q;
  assign ref_a     = best_ref[0];
  assign ref_b     = best_ref[1];
  assign ref_c     = best_ref[2];
endmodule

// File: rtl/zsb_selector_chk.sv
module zsb_selector_chk #(
  parameter int FRAC  = 12,
  parameter int NCAND = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            done,
  input logic [FRAC+1:0] ref_a,
  input logic [FRAC+1:0] ref_b,
  input logic [FRAC+1:0] ref_c
);
  localparam int LW = $clog2(NCAND + 2) + 1;
  localparam logic [FRAC+1:0] THREE_U = (FRAC+2)'(3 * (2 ** FRAC));
  localparam logic [LW-1:0]   LAT_N   = LW'(NCAND);
  localparam logic [LW-1:0]   LAT_MAX = '1;

  // Edges since the accepting edge, counted while a search is open
  logic [LW-1:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat <= '0;
    else if (in_valid && in_ready)       lat <= '0;
    else if (!in_ready && !out_valid && lat != LAT_MAX) lat <= lat + 1'b1;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ref_a) && $stable(ref_b) && $stable(ref_c));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_done_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && !$past(out_valid));

  p_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LAT_N || lat == LW'(1)));

  p_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ref_a <= THREE_U) && (ref_b <= THREE_U) && (ref_c <= THREE_U));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
endmodule

bind zsb_selector zsb_selector_chk #(.FRAC(FRAC), .NCAND(NCAND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done),
  .ref_a     (ref_a),
  .ref_b     (ref_b),
  .ref_c     (ref_c)
);

// File: tb/zsb_selector_test.sv
module zsb_selector_test;
  localparam int FRAC  = 12;
  localparam int IW    = 16;
  localparam int NCAND = 10;
  localparam longint ONE   = 4096;
  localparam longint THREE = 3 * ONE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, done;
  logic signed [FRAC+3:0] fund_a = '0, fund_b = '0, fund_c = '0;
  logic signed [IW-1:0] cur_a = '0, cur_b = '0, cur_c = '0;
  logic signed [IW-1:0] vcap_bot = '0, vcap_mid = '0, vcap_top = '0, vlink = '0;
  logic [FRAC+1:0] ref_a, ref_b, ref_c;

  always #10 clk = ~clk;  // 50 MHz

  zsb_selector #(.FRAC(FRAC), .IW(IW), .NCAND(NCAND)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fund_a(fund_a), .fund_b(fund_b), .fund_c(fund_c),
    .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c),
    .vcap_bot(vcap_bot), .vcap_mid(vcap_mid), .vcap_top(vcap_top), .vlink(vlink),
    .out_valid(out_valid), .out_ready(out_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .done(done)
  );

  int total = 0;
  int bad = 0;
  int f_in [3];
  int i_in [3];
  int v_in [3];
  int vd_in;
  longint exp_ref [3];
  bit     exp_empty;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference model written from the requirements
  function automatic longint score(input longint c);
    longint n1 = 0, n2 = 0, u, lv, fr, a1, a2, a3;
    for (int p = 0; p < 3; p++) begin
      u  = f_in[p] + c;
      lv = u / ONE;
      fr = u % ONE;
      if (lv == 0) n1 += i_in[p] * fr;
      if (lv == 1) begin n1 += i_in[p] * (ONE - fr); n2 += i_in[p] * fr; end
      if (lv == 2) n2 += i_in[p] * (ONE - fr);
    end
    a1 = -n2 - 2 * n1;
    a2 = n1 - n2;
    a3 = 2 * n2 + n1;
    return (3 * longint'(v_in[0]) - vd_in) * a1 + (3 * longint'(v_in[1]) - vd_in) * a2
         + (3 * longint'(v_in[2]) - vd_in) * a3;
  endfunction

  task automatic model();
    longint mn, mx, lo, hi, c, best_c, best, s, u;
    mn = f_in[0]; mx = f_in[0];
    for (int p = 1; p < 3; p++) begin
      if (f_in[p] < mn) mn = f_in[p];
      if (f_in[p] > mx) mx = f_in[p];
    end
    lo = -mn; hi = THREE - mx;
    exp_empty = (hi < lo);
    if (exp_empty) begin
      best_c = (lo + hi) >>> 1;
    end else begin
      best_c = lo; best = 0;
      for (int k = 0; k < NCAND; k++) begin
        c = lo + ((hi - lo) * k) / (NCAND - 1);
        s = score(c);
        if (k == 0 || s < best) begin best = s; best_c = c; end
      end
    end
    for (int p = 0; p < 3; p++) begin
      u = f_in[p] + best_c;
      if (u < 0) u = 0;
      if (u > THREE) u = THREE;
      exp_ref[p] = u;
    end
  endtask

  task automatic run_case(input string tag, input int hold, input bit poke);
    int lat;
    logic [FRAC+1:0] ka, kb, kc;
    model();
    @(negedge clk);
    fund_a = 16'(f_in[0]); fund_b = 16'(f_in[1]); fund_c = 16'(f_in[2]);
    cur_a = 16'(i_in[0]); cur_b = 16'(i_in[1]); cur_c = 16'(i_in[2]);
    vcap_bot = 16'(v_in[0]); vcap_mid = 16'(v_in[1]); vcap_top = 16'(v_in[2]);
    vlink = 16'(vd_in);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      if (lat == 0) in_valid = 1'b0;
      if (poke && lat == 2) begin
        in_valid = 1'b1;
        fund_a = 16'(f_in[0] + 700);
        cur_a = 16'(-i_in[0]);
      end
      if (poke && (lat == 2 || lat == 3)) chk(!in_ready, "R10 in_ready while busy", in_ready, 0);
      if (poke && lat == 4) in_valid = 1'b0;
      if (out_valid || lat > 40) break;
      @(posedge clk);
      lat++;
    end
    chk(lat == (exp_empty ? 1 : NCAND), {tag, " R7 latency"}, lat, exp_empty ? 1 : NCAND);
    chk(done == 1'b1, {tag, " R7 done strobe"}, done, 1);
    chk(ref_a == exp_ref[0], {tag, " ref_a"}, ref_a, exp_ref[0]);
    chk(ref_b == exp_ref[1], {tag, " ref_b"}, ref_b, exp_ref[1]);
    chk(ref_c == exp_ref[2], {tag, " ref_c"}, ref_c, exp_ref[2]);
    ka = ref_a; kb = ref_b; kc = ref_c;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && !done && !in_ready, "R8 held valid", out_valid, 1);
      chk(ref_a == ka && ref_b == kb && ref_c == kc, "R8 held refs", ref_a, ka);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready && !done, "R8 after transfer", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    real th, ph, amp;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    chk(!out_valid && !done, "R9 reset valid/done", out_valid, 0);
    chk(ref_a == 0 && ref_b == 0 && ref_c == 0, "R9 reset refs", ref_a, 0);
    rst_n = 1'b1;

    // Sweep: R1 R2 R3 R4 over angles, depths, offsets, power factors
    for (int idx = 0; idx < 48; idx++) begin
      th  = idx * 6.283185307 / 24.0;
      ph  = (idx % 4) * 0.5;
      amp = ((idx % 2) ? 0.85 : 0.35) * 1.5 * 4096.0;
      f_in[0] = int'(amp * $cos(th));
      f_in[1] = int'(amp * $cos(th - 2.094395102));
      f_in[2] = int'(amp * $cos(th + 2.094395102));
      if (idx % 3 == 0) for (int p = 0; p < 3; p++) f_in[p] += 6144;
      i_in[0] = int'(15000.0 * $cos(th - ph));
      i_in[1] = int'(15000.0 * $cos(th - ph - 2.094395102));
      i_in[2] = int'(15000.0 * $cos(th - ph + 2.094395102));
      v_in[0] = 2000 + ((idx * 37) % 301) - 150;
      v_in[1] = 2000 + ((idx * 53) % 301) - 150;
      v_in[2] = 2000 + ((idx * 71) % 301) - 150;
      vd_in   = 6000 + ((idx * 29) % 201) - 100;
      run_case("R1 R2 R3 R4 sweep", (idx % 5 == 0) ? 3 : 0, idx == 7);
    end

    // R5: zero currents, every score equal, lowest offset kept
    f_in = '{1000, -500, 2000}; i_in = '{0, 0, 0}; v_in = '{2100, 1900, 2050}; vd_in = 6000;
    run_case("R5 tie zero currents", 0, 0);
    // R5: band of zero width
    f_in = '{0, 12288, 4000}; i_in = '{9000, -4000, -5000};
    run_case("R5 zero-width band", 1, 0);
    // R6: reversed band, even and odd sums
    f_in = '{-8192, 10240, 0}; i_in = '{5000, -2000, -3000};
    run_case("R6 reversed band", 2, 0);
    f_in = '{-8193, 10240, 100};
    run_case("R6 reversed odd", 0, 0);
    // R3: references landing on level edges
    f_in = '{4096, 8192, 0}; i_in = '{12000, -7000, -5000}; v_in = '{1800, 2300, 2000}; vd_in = 6100;
    run_case("R3 level edges", 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule